// File: doc/BRIEF.md
# Mixed Push-Pull / Open-Drain I2C Port Expander

This block is an I2C target that runs from the system clock and controls one eight-bit port. Four positions (7, 6, 1, 0) are push-pull outputs. Four positions (5 down to 2) are open-drain lines that can be read back as inputs. The target address is `110` followed by a four-bit value that an external decoder supplies. When a controller writes one byte, that byte sets the push-pull levels. In the same byte, the open-drain positions each hold one bit that both sets the line state and enables the interrupt for that line.

A read returns two bytes that repeat in turn for as long as the controller keeps acknowledging. The first byte holds the live levels of all eight positions. The second byte holds sticky change flags for the four open-drain lines, with the push-pull positions reading as zero. A flag records that the synchronized line level has differed from the level captured when the flag byte was last sent. Loading the flag byte for transmission clears the flags and takes a new snapshot. An active-low interrupt output stays asserted while any enabled flag is set.

Top module: `mixport_expander`

## Requirements
- R1: The target address is 110 in bits 6:4 and `addr_lo` in bits 3:0. An address byte that matches, whether read or write, is acknowledged: SDA is held low during the ninth clock.
- R2: An address that does not match is not acknowledged. Until the next START, no later byte is acknowledged and no byte changes the port outputs.
- R3: Every acknowledged write byte b sets `pp_o` = {b[7], b[6], b[1], b[0]}, so `pp_o[3]` carries bit 7 and `pp_o[0]` carries bit 0.
- R4: For each open-drain line, bits 5:2 of a written byte map to `od_oe[3:0]` (bit 5 to `od_oe[3]`, bit 2 to `od_oe[0]`). The line is pulled low (`od_oe` = 1) only when its bit is 0. The same bit enables that line's interrupt when it is 1.
- R5: The first byte of a read carries the latched push-pull values in bits 7, 6, 1 and 0, and the synchronized `od_i[3:0]` levels in bits 5:2.
- R6: The second byte of a read carries the four change flags in bits 5:2, and zeros in bits 7, 6, 1 and 0.
- R7: A flag sets, and stays set, whenever its synchronized line level differs from the snapshot. At the moment the flag byte is loaded for transmission, all flags clear and the snapshot takes the current levels.
- R8: `int_n` is low exactly while some flag is set whose enable bit is 1. A flag whose enable bit is 0 never pulls `int_n` low.
- R9: While the controller acknowledges, read bytes alternate: level, flags, level, flags. Every new address phase starts again with the level byte.
- R10: After reset, the output latch equals RESET_VAL (all ones by default), the flags are clear, `int_n` is high and SDA is released.
- R11: A START at any point, including partway through a byte, discards the partial byte and begins a new address phase. A STOP returns the target to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCL and SDA are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level as seen on the wire |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| addr_lo | input | 4 | Low four bits of the target address |
| pp_o | output | 4 | Push-pull levels for positions 7, 6, 1, 0 (MSB first) |
| od_i | input | 4 | Pin levels of open-drain positions 5..2 |
| od_oe | output | 4 | Pull-low enables for open-drain positions 5..2 |
| int_n | output | 1 | Active-low change interrupt |

## Verification
A corrupted bus state shows up within one byte. A missing or misplaced ACK becomes visible on the ninth clock, and a bit-order slip corrupts either the next written output or the next byte returned. A wrong flag or snapshot register shows on `int_n` within a few clocks of a line change. It also shows in the very next flag byte: the bench compares that byte against a sticky-OR model that starts again from each flag read. A wrong byte-select bit shows as the level and flag bytes swapping places in a four-byte read.

// File: rtl/mixport_pkg.sv
`timescale 1ns/1ps
package mixport_pkg;

  localparam int          BYTE_W     = 8;
  localparam int          NPORT      = 4;
  localparam logic [2:0]  DEV_PREFIX = 3'b110;

  typedef enum logic [2:0] {
    L_IDLE,
    L_RX,
    L_RX_END,
    L_ACK,
    L_TX,
    L_MACK
  } link_st_t;

  // push-pull positions 7,6,1,0 packed MSB first
  function automatic logic [NPORT-1:0] pp_field(input logic [BYTE_W-1:0] b);
    return {b[7], b[6], b[1], b[0]};
  endfunction

  // open-drain positions 5..2
  function automatic logic [NPORT-1:0] od_field(input logic [BYTE_W-1:0] b);
    return b[5:2];
  endfunction

  function automatic logic [BYTE_W-1:0] level_byte(input logic [BYTE_W-1:0] latch,
                                                   input logic [NPORT-1:0]  pins);
    return {latch[7:6], pins, latch[1:0]};
  endfunction

  function automatic logic [BYTE_W-1:0] flag_byte(input logic [NPORT-1:0] f);
    return {2'b00, f, 2'b00};
  endfunction

  function automatic logic addr_hit(input logic [BYTE_W-1:0] rx,
                                    input logic [3:0]        lo);
    return rx[7:1] == {DEV_PREFIX, lo};
  endfunction

endpackage

// File: rtl/mixport_sync.sv
`timescale 1ns/1ps
module mixport_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= {STAGES{RST_VAL}};
        else        r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/mixport_link.sv
`timescale 1ns/1ps
module mixport_link
  import mixport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [3:0]        addr_lo,
  input  logic [BYTE_W-1:0] lvl_byte,
  input  logic [BYTE_W-1:0] flg_byte,
  output logic              sda_oe,
  output logic              ev_start,
  output logic              ev_stop,
  output logic              ev_addr_hit,
  output logic              ev_wr,
  output logic              ev_load_lvl,
  output logic              ev_load_flg,
  output logic              st_idle,
  output logic [BYTE_W-1:0] rx_byte,
  output logic [BYTE_W-1:0] load_byte
);

  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic              scl_q, sda_q;
  logic              scl_rise, scl_fall;
  link_st_t          st;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] sh, tx;
  logic              addr_phase, rd_mode, sel_flg, mst_ack;
  logic              ev_load;

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign ev_start = scl_s & scl_q & sda_q & ~sda_s;
  assign ev_stop  = scl_s & scl_q & ~sda_q & sda_s;

  assign rx_byte     = sh;
  assign st_idle     = (st == L_IDLE);
  assign ev_addr_hit = (st == L_RX_END) & scl_fall & addr_phase & addr_hit(sh, addr_lo);
  assign ev_wr       = (st == L_RX_END) & scl_fall & ~addr_phase;
  assign ev_load     = scl_fall & (((st == L_ACK) & rd_mode) | ((st == L_MACK) & mst_ack));
  assign ev_load_lvl = ev_load & ~sel_flg;
  assign ev_load_flg = ev_load & sel_flg;
  assign load_byte   = sel_flg ? flg_byte : lvl_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      st         <= L_IDLE;
      cnt        <= '0;
      sh         <= '0;
      tx         <= '0;
      sda_oe     <= 1'b0;
      addr_phase <= 1'b1;
      rd_mode    <= 1'b0;
      sel_flg    <= 1'b0;
      mst_ack    <= 1'b0;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
      if (ev_start) begin
        st         <= L_RX;
        cnt        <= '0;
        addr_phase <= 1'b1;
        sda_oe     <= 1'b0;
      end else if (ev_stop) begin
        st     <= L_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          L_RX: if (scl_rise) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
            if (cnt == LAST) st <= L_RX_END;
          end
          L_RX_END: if (scl_fall) begin
            if (addr_phase) begin
              if (addr_hit(sh, addr_lo)) begin
                sda_oe  <= 1'b1;
                rd_mode <= sh[0];
                sel_flg <= 1'b0;
                st      <= L_ACK;
              end else begin
                st <= L_IDLE;
              end
            end else begin
              sda_oe <= 1'b1;
              st     <= L_ACK;
            end
          end
          L_ACK: if (scl_fall) begin
            addr_phase <= 1'b0;
            cnt        <= '0;
            if (rd_mode) begin
              tx      <= {load_byte[BYTE_W-2:0], 1'b0};
              sda_oe  <= ~load_byte[BYTE_W-1];
              sel_flg <= ~sel_flg;
              st      <= L_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= L_RX;
            end
          end
          L_TX: if (scl_fall) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              sda_oe <= 1'b0;
              st     <= L_MACK;
            end else begin
              sda_oe <= ~tx[BYTE_W-1];
              tx     <= {tx[BYTE_W-2:0], 1'b0};
            end
          end
          L_MACK: begin
            if (scl_rise) begin
              mst_ack <= ~sda_s;
            end else if (scl_fall) begin
              cnt <= '0;
              if (mst_ack) begin
                tx      <= {load_byte[BYTE_W-2:0], 1'b0};
                sda_oe  <= ~load_byte[BYTE_W-1];
                sel_flg <= ~sel_flg;
                st      <= L_TX;
              end else begin
                st <= L_IDLE;
              end
            end
          end
          default: st <= L_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/mixport_ports.sv
`timescale 1ns/1ps
module mixport_ports
  import mixport_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RESET_VAL = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [NPORT-1:0]  od_s,
  input  logic              clr_flags,
  output logic [NPORT-1:0]  pp_o,
  output logic [NPORT-1:0]  od_oe,
  output logic              int_n,
  output logic [BYTE_W-1:0] lvl_byte,
  output logic [BYTE_W-1:0] flg_byte,
  output logic [NPORT-1:0]  flags,
  output logic [NPORT-1:0]  mask
);

  logic [BYTE_W-1:0] latch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     latch <= RESET_VAL;
    else if (wr_en) latch <= wr_data;
  end

  assign pp_o  = pp_field(latch);
  assign mask  = od_field(latch);
  assign od_oe = ~od_field(latch);

  generate
    for (genvar i = 0; i < NPORT; i++) begin : g_port
      logic f_q, s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          f_q <= 1'b0;
          s_q <= RESET_VAL[i+2];
        end else if (clr_flags) begin
          f_q <= 1'b0;
          s_q <= od_s[i];
        end else if (od_s[i] != s_q) begin
          f_q <= 1'b1;
        end
      end
      assign flags[i] = f_q;
    end
  endgenerate

  assign int_n    = ~|(flags & mask);
  assign lvl_byte = level_byte(latch, od_s);
  assign flg_byte = flag_byte(flags);

endmodule

// File: rtl/mixport_expander.sv
`timescale 1ns/1ps
module mixport_expander
  import mixport_pkg::*;
#(
  parameter logic [7:0] RESET_VAL   = 8'hFF,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [3:0] addr_lo,
  output logic [3:0] pp_o,
  input  logic [3:0] od_i,
  output logic [3:0] od_oe,
  output logic       int_n
);

  logic              scl_s, sda_s;
  logic [NPORT-1:0]  od_s;
  logic              ev_start, ev_stop, ev_addr_hit, ev_wr;
  logic              ev_load_lvl, ev_load_flg, st_idle;
  logic [BYTE_W-1:0] rx_byte, load_byte, lvl_byte, flg_byte;
  logic [NPORT-1:0]  flags, mask;

  mixport_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  mixport_sync #(.WIDTH(NPORT), .STAGES(SYNC_STAGES), .RST_VAL(od_field(RESET_VAL))) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(od_i), .q(od_s)
  );

  mixport_link u_link (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .addr_lo(addr_lo),
    .lvl_byte(lvl_byte), .flg_byte(flg_byte), .sda_oe(sda_oe),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_addr_hit(ev_addr_hit), .ev_wr(ev_wr),
    .ev_load_lvl(ev_load_lvl), .ev_load_flg(ev_load_flg), .st_idle(st_idle),
    .rx_byte(rx_byte), .load_byte(load_byte)
  );

  mixport_ports #(.RESET_VAL(RESET_VAL)) u_ports (
    .clk(clk), .rst_n(rst_n), .wr_en(ev_wr), .wr_data(rx_byte), .od_s(od_s),
    .clr_flags(ev_load_flg), .pp_o(pp_o), .od_oe(od_oe), .int_n(int_n),
    .lvl_byte(lvl_byte), .flg_byte(flg_byte), .flags(flags), .mask(mask)
  );

endmodule

// File: rtl/mixport_checker.sv
`timescale 1ns/1ps
module mixport_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       scl_s,
  input logic       int_n,
  input logic       st_idle,
  input logic       ev_wr,
  input logic       ev_load_flg,
  input logic       ev_addr_hit,
  input logic [7:0] rx_byte,
  input logic [7:0] load_byte,
  input logic [3:0] addr_lo,
  input logic [3:0] pp_o,
  input logic [3:0] od_oe,
  input logic [3:0] flags
);

  // R1: SDA only moves while the synchronized clock is low
  p_sda_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R1: an acknowledged address carries the expected prefix and low bits
  p_addr_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_hit |-> (rx_byte[7:1] == {3'b110, addr_lo}));

  // R2: an idle (ignoring) target never drives SDA
  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> !sda_oe);

  // R3: written byte reaches the push-pull pins one cycle later
  p_write_pp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |=> (pp_o == {$past(rx_byte[7:6]), $past(rx_byte[1:0])}));

  // R4: open-drain enables are the inverse of written bits 5:2
  p_write_od_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |=> (od_oe == ~$past(rx_byte[5:2])));

  // R6: flag byte has zeros in push-pull positions
  p_flag_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load_flg |-> (load_byte[7:6] == 2'b00 && load_byte[1:0] == 2'b00));

  // R7: flags clear when the flag byte is loaded
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load_flg |=> (flags == 4'b0000));

  // R7: flags are sticky otherwise
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_load_flg |=> ((flags & $past(flags)) == $past(flags)));

  // R8: interrupt released after the flag byte is loaded
  p_int_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load_flg |=> int_n);

endmodule

bind mixport_expander mixport_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s), .int_n(int_n),
  .st_idle(st_idle), .ev_wr(ev_wr), .ev_load_flg(ev_load_flg),
  .ev_addr_hit(ev_addr_hit), .rx_byte(rx_byte), .load_byte(load_byte),
  .addr_lo(addr_lo), .pp_o(pp_o), .od_oe(od_oe), .flags(flags)
);

// File: tb/sim_mixport_expander.sv
`timescale 1ns/1ps
module sim_mixport_expander;

  localparam int         Q   = 4;
  localparam logic [6:0] DEV = 7'b110_1010;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [3:0] addr_lo = 4'hA;
  logic [3:0] ext = 4'hF;

  logic       sda_oe, int_n;
  logic [3:0] pp_o, od_oe;
  logic       sda_line;
  logic [3:0] pin_lvl;

  assign sda_line = m_sda & ~sda_oe;
  assign pin_lvl  = ext & ~od_oe;

  always #2 clk = ~clk;

  mixport_expander u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_lo(addr_lo), .pp_o(pp_o), .od_i(pin_lvl), .od_oe(od_oe), .int_n(int_n)
  );

  int n_vec = 0;
  int n_bad = 0;

  logic [7:0] m_lat  = 8'hFF;
  logic [3:0] m_snap = 4'hF;
  logic [3:0] m_flg  = 4'h0;
  logic [7:0] rb [4];

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pins_now();
    return m_lat[5:2] & ext;
  endfunction

  task automatic touch();
    m_flg = m_flg | (pins_now() ^ m_snap);
  endtask

  function automatic logic exp_int();
    return ~|(m_flg & m_lat[5:2]);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  task automatic bus_bit(input logic b, output logic seen);
    m_sda = b; tick(Q); m_scl = 1'b1; tick(Q); seen = sda_line; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, ack);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      b[i] = s;
    end
    bus_bit(~give_ack, s);
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] d, output logic a1, output logic a2);
    bus_start();
    send_byte({a, 1'b0}, a1);
    send_byte(d, a2);
    bus_stop();
  endtask

  task automatic rd_txn(input int n);
    logic a;
    bus_start();
    send_byte({DEV, 1'b1}, a);
    check("R1 read address ack", {7'd0, a}, 8'd0);
    for (int i = 0; i < n; i++) recv_byte(rb[i], i < n - 1);
    bus_stop();
  endtask

  task automatic check_ports(input string req);
    check(req, {4'd0, pp_o}, {4'd0, m_lat[7], m_lat[6], m_lat[1], m_lat[0]});
    check(req, {4'd0, od_oe}, {4'd0, ~m_lat[5:2]});
  endtask

  task automatic read_pair_check();
    logic [7:0] e_lvl, e_flg;
    rd_txn(2);
    e_lvl = {m_lat[7:6], pins_now(), m_lat[1:0]};
    e_flg = {2'b00, m_flg, 2'b00};
    check("R5 level byte", rb[0], e_lvl);
    check("R6 flag byte", rb[1], e_flg);
    m_flg  = 4'h0;
    m_snap = pins_now();
    tick(8);
    check("R8 int released after flag read", {7'd0, int_n}, 8'd1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    logic a1, a2;
    logic [7:0] d;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R10 reset state
    check("R10 pp after reset", {4'd0, pp_o}, 8'h0F);
    check("R10 od_oe after reset", {4'd0, od_oe}, 8'h00);
    check("R10 int_n after reset", {7'd0, int_n}, 8'd1);
    check("R10 sda released", {7'd0, sda_oe}, 8'd0);
    read_pair_check();

    // R1 / R2 sweep of every 7-bit address
    for (int a = 0; a < 128; a++) begin
      d = 8'(a) ^ 8'h3C;
      wr_txn(7'(a), d, a1, a2);
      if (7'(a) == DEV) begin
        check("R1 address ack", {7'd0, a1}, 8'd0);
        check("R3 data ack", {7'd0, a2}, 8'd0);
        m_lat = d;
        touch();
      end else begin
        check("R2 address nack", {7'd0, a1}, 8'd1);
        check("R2 data ignored nack", {7'd0, a2}, 8'd1);
      end
      check_ports("R2 R3 R4 outputs after sweep write");
    end
    tick(8);
    check("R8 masked flags keep int high", {7'd0, int_n}, {7'd0, exp_int()});
    read_pair_check();

    // R3 R4 R5 R6 R8 sweep of output/mask and pin patterns
    for (int k = 0; k < 16; k++) begin
      d = 8'((k * 37 + 11) ^ (k << 4));
      wr_txn(DEV, d, a1, a2);
      check("R3 write ack", {6'd0, a1, a2}, 8'd0);
      m_lat = d;
      touch();
      check_ports("R3 R4 outputs");
      ext = 4'(k) ^ 4'h6;
      touch();
      tick(8);
      check("R8 int_n vs enabled flags", {7'd0, int_n}, {7'd0, exp_int()});
      read_pair_check();
      ext = 4'hF;
      touch();
    end

    // R7 sticky flag and R9 alternating four-byte read
    wr_txn(DEV, 8'hFF, a1, a2);
    m_lat = 8'hFF;
    touch();
    read_pair_check();
    ext = 4'hE; tick(8);
    touch();
    ext = 4'hF; tick(8);
    check("R7 sticky flag drives int", {7'd0, int_n}, 8'd0);
    rd_txn(4);
    check("R9 byte0 level", rb[0], 8'hFF);
    check("R9 byte1 flags", rb[1], 8'h04);
    check("R9 byte2 level again", rb[2], 8'hFF);
    check("R7 R9 byte3 flags cleared", rb[3], 8'h00);
    m_flg = 4'h0;
    m_snap = pins_now();

    // R8 disabled ports: pulled low, flags set, no interrupt
    wr_txn(DEV, 8'hC3, a1, a2);
    m_lat = 8'hC3;
    touch();
    ext = 4'h5; tick(8);
    touch();
    check("R8 disabled flags no int", {7'd0, int_n}, 8'd1);
    read_pair_check();
    ext = 4'hF;

    // R11 START in the middle of a byte aborts it
    bus_start();
    send_byte({DEV, 1'b0}, a1);
    for (int i = 0; i < 4; i++) bus_bit(1'b0, a2);
    bus_start();
    send_byte({~DEV, 1'b0}, a1);
    bus_stop();
    check("R11 aborted byte nack", {7'd0, a1}, 8'd1);
    check_ports("R11 outputs unchanged after abort");

    // R11 write then repeated START read
    bus_start();
    send_byte({DEV, 1'b0}, a1);
    send_byte(8'h9F, a2);
    m_lat = 8'h9F;
    touch();
    bus_start();
    send_byte({DEV, 1'b1}, a1);
    check("R11 repeated start ack", {7'd0, a1}, 8'd0);
    recv_byte(rb[0], 1'b0);
    bus_stop();
    check("R11 level after repeated start", rb[0], {m_lat[7:6], pins_now(), m_lat[1:0]});
    check_ports("R11 outputs after repeated start");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule